// File: doc/BRIEF.md
# Mode Control Register Unit

This block holds the device's main mode word. A host port writes and reads it. Its fields drive the rest of the device directly: the colour depth of the lookup path, the width of the host data bus and the operating mode. It also compares two external select pins against two stored match bits and gates the video output enable with the result.

Two fields do not act as plain levels. They watch the history of host writes instead. One bit must be written high, then low, then high again before the unit issues a single-cycle restart pulse to the pixel sequencer. That pulse moves the four-phase pixel order back to its first phase. A second bit issues a single-cycle calibration start pulse only when a write moves it from 0 to 1. The sequencer and the calibration logic belong to other blocks, and this unit produces only their trigger pulses.

Top module: `mode_ctl_reg`

## Requirements
- R1: Reading back returns the eight low bits last written (bit positions 7..0). The two top bits of the 10-bit word always read as zero, whatever value was written to them.
- R2: `res_10bit` follows stored bit 1: 1 selects 10-bit colour, 0 selects 8-bit colour.
- R3: `bus_10bit` follows stored bit 2: 1 selects a 10-bit host bus, 0 selects an 8-bit host bus.
- R4: `op_mode` equals stored bits 4..3. `mode_normal` is 1 only when that code is 00, and the codes 01, 10 and 11 are reserved.
- R5: `seq_restart` is high for exactly one cycle, in the cycle after the third of three successive writes that carry bit 0 as 1, 0, 1. That closing 1 also counts as the first step of the next pattern, so 1,0,1,0,1 gives two pulses.
- R6: A write that breaks the 1,0,1 pattern on bit 0 restarts detection. After 1,1 the second 1 is a new first step, so 1,1,0,1 fires on the fourth write. After 1,0,0 the detector is idle, so 1,0,0,1 gives no pulse.
- R7: `cal_start` is high for one cycle, in the cycle after a write that sets bit 5 to 1 while the stored bit 5 is 0. Writing 1 over a stored 1 gives no pulse.
- R8: `video_en` is 1 exactly when `pal_sel[1]` equals stored bit 7 and `pal_sel[0]` equals stored bit 6. It is combinational in `pal_sel`.
- R9: An active-low reset clears the stored word to zero, drops both pulses and returns the bit-0 detector to idle, so a write pattern split across a reset does not fire.
- R10: While `wr_en` is low the stored word is unchanged, whatever is on `wr_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Host write strobe for the mode word |
| wr_data | input | 10 | Host write data |
| pal_sel | input | 2 | External palette select pins |
| rd_data | output | 10 | Read-back of the mode word |
| res_10bit | output | 1 | Colour resolution select |
| bus_10bit | output | 1 | Host bus width select |
| op_mode | output | 2 | Operating mode code |
| mode_normal | output | 1 | Operating mode is normal |
| seq_restart | output | 1 | One-cycle pixel sequencer restart |
| cal_start | output | 1 | One-cycle calibration start |
| video_en | output | 1 | Video output enable from the select match |

## Verification
The bench builds the block with its default register width, W = 10. At that width the whole write space of 1024 values can be swept. Each value is checked against all four select-pin combinations, which covers every field decode and every reserved-bit case. Directed write sequences on bit 0 and bit 5 then cover the pulse corners: overlapping patterns, broken patterns, repeated writes of 1, and a reset that lands in the middle of a pattern.

// File: rtl/mode_ctl_reg.sv
module mode_ctl_reg #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic [1:0]   pal_sel,
  output logic [W-1:0] rd_data,
  output logic         res_10bit,
  output logic         bus_10bit,
  output logic [1:0]   op_mode,
  output logic         mode_normal,
  output logic         seq_restart,
  output logic         cal_start,
  output logic         video_en
);
  localparam int FW = 8;
  localparam int PAD = W - FW;

  typedef enum logic [1:0] {PAT_IDLE, PAT_ONE, PAT_ONE_ZERO} pat_t;

  logic [FW-1:0] word_q;
  pat_t          pat_q;
  logic          unused_hi;

  assign unused_hi = ^wr_data[W-1:FW];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q      <= '0;
      pat_q       <= PAT_IDLE;
      seq_restart <= 1'b0;
      cal_start   <= 1'b0;
    end else begin
      seq_restart <= 1'b0;
      cal_start   <= 1'b0;
      if (wr_en) begin
        word_q    <= wr_data[FW-1:0];
        cal_start <= wr_data[5] & ~word_q[5];
        if (wr_data[0]) begin
          seq_restart <= (pat_q == PAT_ONE_ZERO);
          pat_q       <= PAT_ONE;
        end else begin
          pat_q <= (pat_q == PAT_ONE) ? PAT_ONE_ZERO : PAT_IDLE;
        end
      end
    end
  end

  assign rd_data     = {{PAD{1'b0}}, word_q};
  assign res_10bit   = word_q[1];
  assign bus_10bit   = word_q[2];
  assign op_mode     = word_q[4:3];
  assign mode_normal = (word_q[4:3] == 2'b00);
  assign video_en    = (pal_sel == word_q[7:6]);
endmodule

// File: rtl/mode_ctl_reg_chk.sv
module mode_ctl_reg_chk #(
  parameter int W = 10
) (
  input logic         clk,
  input logic         rst_n,
  input logic         wr_en,
  input logic [W-1:0] wr_data,
  input logic [1:0]   pal_sel,
  input logic [W-1:0] rd_data,
  input logic [1:0]   op_mode,
  input logic         mode_normal,
  input logic         seq_restart,
  input logic         cal_start,
  input logic         video_en
);
  p_resv_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[W-1:8] == '0);

  p_normal_only_00_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mode_normal == (op_mode == 2'b00));

  p_restart_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    seq_restart |=> !seq_restart);

  p_restart_after_one_r5: assert property (@(posedge clk) disable iff (!rst_n)
    seq_restart |-> $past(wr_en && wr_data[0]));

  p_cal_rising_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cal_start |-> $past(wr_en && wr_data[5] && !rd_data[5]));

  p_cal_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cal_start |=> !cal_start);

  p_select_match_r8: assert property (@(posedge clk) disable iff (!rst_n)
    video_en == (pal_sel == rd_data[7:6]));

  p_hold_no_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(rd_data));
endmodule

bind mode_ctl_reg mode_ctl_reg_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
  .pal_sel(pal_sel), .rd_data(rd_data), .op_mode(op_mode),
  .mode_normal(mode_normal), .seq_restart(seq_restart),
  .cal_start(cal_start), .video_en(video_en)
);

// File: tb/test_mode_ctl_reg.sv
module test_mode_ctl_reg;
  localparam int CLK_PERIOD = 10;
  localparam int W = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [W-1:0] wr_data = '0;
  logic [1:0] pal_sel = 2'b00;
  logic [W-1:0] rd_data;
  logic res_10bit, bus_10bit, mode_normal, seq_restart, cal_start, video_en;
  logic [1:0] op_mode;

  int n_checks = 0;
  int n_fails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mode_ctl_reg #(.W(W)) i_mode_ctl_reg (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .pal_sel(pal_sel), .rd_data(rd_data), .res_10bit(res_10bit),
    .bus_10bit(bus_10bit), .op_mode(op_mode), .mode_normal(mode_normal),
    .seq_restart(seq_restart), .cal_start(cal_start), .video_en(video_en)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [W-1:0] d);
    @(negedge clk);
    wr_en = 1'b1;
    wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic hw_reset();
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wr_seq(input string req, input logic [W-1:0] d, input bit exp_pulse);
    wr(d);
    chk(req, seq_restart, exp_pulse);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    chk("R9 reset word", rd_data, 0);
    chk("R9 reset restart", seq_restart, 0);
    chk("R9 reset cal", cal_start, 0);
    chk("R8 reset select", video_en, 1);
    rst_n = 1'b1;

    // R1 R2 R3 R4 R8: sweep the whole write space and all pin values
    for (int v = 0; v < (1 << W); v++) begin
      wr(W'(v));
      chk("R1 readback", rd_data, v & 8'hFF);
      chk("R2 resolution", res_10bit, (v >> 1) & 1);
      chk("R3 bus width", bus_10bit, (v >> 2) & 1);
      chk("R4 mode code", op_mode, (v >> 3) & 3);
      chk("R4 normal flag", mode_normal, ((v >> 3) & 3) == 0 ? 1 : 0);
      for (int s = 0; s < 4; s++) begin
        pal_sel = 2'(s);
        #1;
        chk("R8 select match", video_en, (s == ((v >> 6) & 3)) ? 1 : 0);
      end
    end

    // R10: strobe low, data moving
    wr(10'h0A5);
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      wr_data = 10'(k * 37 + 1);
      chk("R10 hold", rd_data, 8'hA5);
    end

    // R5 basic and one-cycle width
    hw_reset();
    wr_seq("R5 step1", 10'h001, 0);
    wr_seq("R5 step2", 10'h000, 0);
    wr_seq("R5 step3", 10'h001, 1);
    @(negedge clk);
    chk("R5 width", seq_restart, 0);

    // R5 overlap: 1,0,1,0,1
    hw_reset();
    wr_seq("R5 ov1", 10'h001, 0);
    wr_seq("R5 ov2", 10'h000, 0);
    wr_seq("R5 ov3", 10'h001, 1);
    wr_seq("R5 ov4", 10'h000, 0);
    wr_seq("R5 ov5", 10'h001, 1);

    // R6 restarts
    hw_reset();
    wr_seq("R6 a1", 10'h001, 0);
    wr_seq("R6 a2", 10'h001, 0);
    wr_seq("R6 a3", 10'h000, 0);
    wr_seq("R6 a4", 10'h001, 1);
    hw_reset();
    wr_seq("R6 b1", 10'h001, 0);
    wr_seq("R6 b2", 10'h000, 0);
    wr_seq("R6 b3", 10'h000, 0);
    wr_seq("R6 b4", 10'h001, 0);

    // R9 pattern split by reset
    hw_reset();
    wr_seq("R9 p1", 10'h001, 0);
    wr_seq("R9 p2", 10'h000, 0);
    hw_reset();
    wr_seq("R9 p3", 10'h001, 0);

    // R7 calibration edge
    hw_reset();
    wr(10'h020);
    chk("R7 rise", cal_start, 1);
    @(negedge clk);
    chk("R7 width", cal_start, 0);
    wr(10'h020);
    chk("R7 hold high", cal_start, 0);
    wr(10'h000);
    chk("R7 fall", cal_start, 0);
    wr(10'h0E0);
    chk("R7 rise again", cal_start, 1);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule